// File: doc/BRIEF.md
# PCI Bridge Error Response Unit

This unit sits beside the data paths of a bridge between a PCI-style external bus and an on-chip system bus and decides what happens to data when a transfer goes wrong. Traffic the system side sends out to PCI (outbound) and traffic PCI masters send into the chip (inbound) each have a fixed response to failure. An outbound write that is aborted loses its buffered data. An outbound read that is aborted is still answered with the full number of words, the missing ones filled with all-ones and marked as errors. Inbound data with a parity error or an exception flag is forwarded unchanged. Nothing is ever retried.

Every error class sets its own sticky status bit in one small control register that also holds the per-class interrupt enables. The system-management interrupt is the OR of enabled, set status bits. The PCI protocol engine and the parity logic are outside this unit. They appear only as valid, abort and error strobes.

Top module: `pci_bridge_err_handler`

## Requirements
- R1: Outbound write words pushed while `obw_full` is low are presented on `obw_rdata` in push order. `obw_avail` is high while any word is stored. `obw_full` is high when DEPTH words are stored, and a push while full is dropped.
- R2: A pulse on `obw_mabort` or `obw_tabort` discards every stored outbound write word. From the next cycle `obw_avail` and `obw_full` are low, and a push in the abort cycle is also dropped.
- R3: After `obr_start` with a nonzero `obr_len` is accepted while `obr_busy` is low, each `obr_pci_valid` word appears on `rsp_data` one cycle later with `rsp_valid` high and `rsp_err` low. `rsp_last` is high on word number `obr_len`, and `obr_busy` then falls.
- R4: If `obr_mabort` or `obr_tabort` pulses while a read is open, the data word of that cycle is dropped. From the following cycle the unit emits one word per cycle for each word still owed, with `rsp_data` all ones and `rsp_err` high, so the requester gets exactly `obr_len` words in total. `rsp_last` is high on the final one.
- R5: The status bits are `csr_rdata[4]` (master abort, from either direction), `[5]` (target abort), `[6]` (inbound write parity error) and `[7]` (inbound read exception). Each is set the cycle after its event and stays set until a write with `csr_we` high and a 1 in the matching `csr_wdata[7:4]` bit. A set in the same cycle as a clear wins.
- R6: The enables are `csr_rdata[3:0]` and are loaded from `csr_wdata[3:0]` on every `csr_we`; they reset to zero. `smi_irq` equals the OR over i of status[i] AND enable[i]. It is therefore low while the enables are zero, and it falls the cycle after a clearing write.
- R7: An inbound write word (`ibw_valid`) is forwarded on `sysw_valid`/`sysw_data` one cycle later with its data unchanged, even when `ibw_perr` is high. With `ibw_perr` high it also sets status bit 6.
- R8: An exception the system bus reports for a posted inbound write (`sysw_excep`) changes neither the status bits nor `smi_irq`.
- R9: Inbound read words (`sysr_valid`) appear on `pcir_valid`/`pcir_data` one cycle later unchanged, whether or not `sysr_excep` is set. A word with `sysr_excep` set sets status bit 7.
- R10: After an abort, no transfer is retried. No outbound read response appears after the final word until a new `obr_start`, and discarded write words never reappear on `obw_avail`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| obw_push | input | 1 | System side stores an outbound write word |
| obw_data | input | DW | Outbound write word |
| obw_full | output | 1 | Outbound write buffer full |
| obw_pop | input | 1 | PCI engine consumed the head word |
| obw_avail | output | 1 | Outbound write buffer holds data |
| obw_rdata | output | DW | Head outbound write word |
| obw_mabort | input | 1 | Outbound write ended in master abort |
| obw_tabort | input | 1 | Outbound write ended in target abort |
| obr_start | input | 1 | System side opens an outbound read |
| obr_len | input | LW | Words owed for the read |
| obr_busy | output | 1 | Outbound read open |
| obr_pci_valid | input | 1 | PCI engine delivers a read word |
| obr_pci_data | input | DW | Read word from PCI |
| obr_mabort | input | 1 | Outbound read ended in master abort |
| obr_tabort | input | 1 | Outbound read ended in target abort |
| rsp_valid | output | 1 | Read response word to the system side |
| rsp_data | output | DW | Read response data |
| rsp_err | output | 1 | Response word is filler after an abort |
| rsp_last | output | 1 | Final word of the read |
| ibw_valid | input | 1 | Inbound posted write word from PCI |
| ibw_data | input | DW | Inbound write data |
| ibw_perr | input | 1 | Parity error detected on the inbound word |
| sysw_valid | output | 1 | Forwarded inbound write word |
| sysw_data | output | DW | Forwarded inbound write data |
| sysw_excep | input | 1 | System bus exception for a posted write |
| sysr_valid | input | 1 | Inbound read data from the system bus |
| sysr_data | input | DW | Inbound read data |
| sysr_excep | input | 1 | Exception flag on that read word |
| pcir_valid | output | 1 | Read word toward PCI |
| pcir_data | output | DW | Read data toward PCI |
| csr_we | input | 1 | Control register write |
| csr_wdata | input | 8 | [3:0] enables, [7:4] write-1-to-clear status |
| csr_rdata | output | 8 | {status[3:0], enable[3:0]} |
| smi_irq | output | 1 | System-management interrupt |

## Verification
The bench aborts an outbound read after one word has arrived. A design that pads by the original length rather than the remaining one, or that keeps the dropped word of the abort cycle, sends the requester the wrong number of words or a real word where filler belongs. It fills the write buffer to capacity and pushes once more, then aborts a partly filled buffer. A stale pointer or count would show up as a reappearing word or a stuck `obw_avail`. It raises a target abort in the same cycle as the write that clears that status bit, which catches clear-priority mistakes. It drives parity-corrupted inbound writes, flagged inbound reads and posted-write exceptions, and checks the data bit for bit. That catches any design that masks corrupted data or lets a posted-write exception reach the status or interrupt.

// File: rtl/bridge_err_pkg.sv
`timescale 1ns/1ps
package bridge_err_pkg;
   typedef enum logic [1:0] {
      RD_IDLE   = 2'd0,
      RD_ACTIVE = 2'd1,
      RD_PAD    = 2'd2
   } rd_state_t;

   localparam int NUM_CAUSES = 4;
   localparam int CAUSE_MABORT = 0;
   localparam int CAUSE_TABORT = 1;
   localparam int CAUSE_IBPERR = 2;
   localparam int CAUSE_IBREXC = 3;
endpackage

// File: rtl/ob_wr_buffer.sv
`timescale 1ns/1ps
module ob_wr_buffer #(
   parameter int DW    = 32,
   parameter int DEPTH = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [DW-1:0] din,
   input  logic          pop,
   input  logic          flush,
   output logic [DW-1:0] dout,
   output logic          avail,
   output logic          full
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   if (DEPTH < 1) begin : g_bad_depth
      $error("ob_wr_buffer: DEPTH must be at least 1");
   end
   if ((DEPTH & (DEPTH - 1)) != 0) begin : g_bad_pow2
      $error("ob_wr_buffer: DEPTH must be a power of two");
   end

   logic do_push;
   logic do_pop;

   always_comb begin
      do_push = push && !full && !flush;
      do_pop  = pop && avail && !flush;
   end

   if (DEPTH == 1) begin : g_single
      logic [DW-1:0] hold_q;
      logic          hold_v;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            hold_v <= 1'b0;
         end else if (flush) begin
            hold_v <= 1'b0;
         end else if (do_push) begin
            hold_v <= 1'b1;
         end else if (do_pop) begin
            hold_v <= 1'b0;
         end
      end

      always_ff @(posedge clk) begin
         if (do_push) begin
            hold_q <= din;
         end
      end

      always_comb begin
         dout  = hold_q;
         avail = hold_v;
         full  = hold_v;
      end
   end else begin : g_ring
      logic [DW-1:0] mem [DEPTH];
      logic [AW-1:0] wr_ptr;
      logic [AW-1:0] rd_ptr;
      logic [CW-1:0] count;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
         end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
         end else begin
            if (do_push) begin
               wr_ptr <= wr_ptr + AW'(1);
            end
            if (do_pop) begin
               rd_ptr <= rd_ptr + AW'(1);
            end
            count <= count + CW'(do_push) - CW'(do_pop);
         end
      end

      always_ff @(posedge clk) begin
         if (do_push) begin
            mem[wr_ptr] <= din;
         end
      end

      always_comb begin
         dout  = mem[rd_ptr];
         avail = (count != '0);
         full  = (count == CW'(DEPTH));
      end
   end

   // R2: an abort leaves nothing behind
   a_r2_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (!avail && !full));

   // R1: no push is taken while full
   a_r1_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !pop && !flush) |=> full);
endmodule

// File: rtl/ob_rd_tracker.sv
`timescale 1ns/1ps
module ob_rd_tracker
   import bridge_err_pkg::*;
#(
   parameter int DW = 32,
   parameter int LW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [LW-1:0] len,
   input  logic          pci_valid,
   input  logic [DW-1:0] pci_data,
   input  logic          abort,
   output logic          busy,
   output logic          rsp_valid,
   output logic [DW-1:0] rsp_data,
   output logic          rsp_err,
   output logic          rsp_last
);
   if (LW < 1) begin : g_bad_lw
      $error("ob_rd_tracker: LW must be at least 1");
   end

   localparam logic [DW-1:0] FILL_WORD = '1;

   rd_state_t     state;
   logic [LW-1:0] remain;
   logic          final_word;

   always_comb begin
      final_word = (remain == LW'(1));
      busy       = (state != RD_IDLE);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= RD_IDLE;
         remain    <= '0;
         rsp_valid <= 1'b0;
         rsp_data  <= '0;
         rsp_err   <= 1'b0;
         rsp_last  <= 1'b0;
      end else begin
         rsp_valid <= 1'b0;
         rsp_err   <= 1'b0;
         rsp_last  <= 1'b0;
         unique case (state)
            RD_IDLE: begin
               if (start && (len != '0)) begin
                  remain <= len;
                  state  <= RD_ACTIVE;
               end
            end
            RD_ACTIVE: begin
               if (abort) begin
                  state <= RD_PAD;
               end else if (pci_valid) begin
                  rsp_valid <= 1'b1;
                  rsp_data  <= pci_data;
                  rsp_last  <= final_word;
                  remain    <= remain - LW'(1);
                  if (final_word) begin
                     state <= RD_IDLE;
                  end
               end
            end
            RD_PAD: begin
               rsp_valid <= 1'b1;
               rsp_data  <= FILL_WORD;
               rsp_err   <= 1'b1;
               rsp_last  <= final_word;
               remain    <= remain - LW'(1);
               if (final_word) begin
                  state <= RD_IDLE;
               end
            end
            default: state <= RD_IDLE;
         endcase
      end
   end

   // R4: filler words are all ones
   a_r4_fill_ones: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_err) |-> (rsp_data == FILL_WORD));

   // R4: an abort during a read is followed by filler
   a_r4_abort_pads: assert property (@(posedge clk) disable iff (!rst_n)
      (state == RD_ACTIVE && abort) |=> (state == RD_PAD));

   // R10: an idle tracker without a start produces nothing
   a_r10_no_retry: assert property (@(posedge clk) disable iff (!rst_n)
      (state == RD_IDLE && !start) |=> !rsp_valid);

   // R3: the final word closes the read
   a_r3_last_closes: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_last) |-> !busy);
endmodule

// File: rtl/ib_pass_stage.sv
`timescale 1ns/1ps
module ib_pass_stage #(
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic [DW-1:0] in_data,
   output logic          out_valid,
   output logic [DW-1:0] out_data
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_data <= in_data;
         end
      end
   end

   // R7 / R9: data crosses untouched, one cycle later
   a_r7_pass_unchanged: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (out_valid && out_data == $past(in_data)));
endmodule

// File: rtl/err_csr.sv
`timescale 1ns/1ps
module err_csr #(
   parameter int NC = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NC-1:0] set_vec,
   input  logic          we,
   input  logic [2*NC-1:0] wdata,
   output logic [2*NC-1:0] rdata,
   output logic          irq
);
   if (NC < 1) begin : g_bad_nc
      $error("err_csr: NC must be at least 1");
   end

   logic [NC-1:0] status;
   logic [NC-1:0] enable;

   for (genvar i = 0; i < NC; i++) begin : g_cause
      logic clr_i;
      always_comb clr_i = we && wdata[NC + i];

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            status[i] <= 1'b0;
         end else if (set_vec[i]) begin
            status[i] <= 1'b1;
         end else if (clr_i) begin
            status[i] <= 1'b0;
         end
      end

      // R5: a status bit stays set until cleared
      a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
         (status[i] && !clr_i) |=> status[i]);

      // R5: an event always leaves its bit set
      a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
         set_vec[i] |=> status[i]);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         enable <= '0;
      end else if (we) begin
         enable <= wdata[NC-1:0];
      end
   end

   always_comb begin
      rdata = {status, enable};
      irq   = |(status & enable);
   end

   // R6: no interrupt without an enabled, set cause
   a_r6_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (enable == '0) |-> !irq);
endmodule

// File: rtl/pci_bridge_err_handler.sv
`timescale 1ns/1ps
module pci_bridge_err_handler
   import bridge_err_pkg::*;
#(
   parameter int DW    = 32,
   parameter int DEPTH = 4,
   parameter int LW    = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          obw_push,
   input  logic [DW-1:0] obw_data,
   output logic          obw_full,
   input  logic          obw_pop,
   output logic          obw_avail,
   output logic [DW-1:0] obw_rdata,
   input  logic          obw_mabort,
   input  logic          obw_tabort,
   input  logic          obr_start,
   input  logic [LW-1:0] obr_len,
   output logic          obr_busy,
   input  logic          obr_pci_valid,
   input  logic [DW-1:0] obr_pci_data,
   input  logic          obr_mabort,
   input  logic          obr_tabort,
   output logic          rsp_valid,
   output logic [DW-1:0] rsp_data,
   output logic          rsp_err,
   output logic          rsp_last,
   input  logic          ibw_valid,
   input  logic [DW-1:0] ibw_data,
   input  logic          ibw_perr,
   output logic          sysw_valid,
   output logic [DW-1:0] sysw_data,
   input  logic          sysw_excep,
   input  logic          sysr_valid,
   input  logic [DW-1:0] sysr_data,
   input  logic          sysr_excep,
   output logic          pcir_valid,
   output logic [DW-1:0] pcir_data,
   input  logic          csr_we,
   input  logic [7:0]    csr_wdata,
   output logic [7:0]    csr_rdata,
   output logic          smi_irq
);
   if (DW < 8) begin : g_bad_dw
      $error("pci_bridge_err_handler: DW must be at least 8");
   end
   if (NUM_CAUSES != 4) begin : g_bad_nc
      $error("pci_bridge_err_handler: control register expects four causes");
   end

   logic                  wr_abort;
   logic                  rd_abort;
   logic [NUM_CAUSES-1:0] cause_set;
   logic                  posted_excep_unused;

   always_comb begin
      wr_abort = obw_mabort || obw_tabort;
      rd_abort = obr_mabort || obr_tabort;
      cause_set = '0;
      cause_set[CAUSE_MABORT] = obw_mabort || obr_mabort;
      cause_set[CAUSE_TABORT] = obw_tabort || obr_tabort;
      cause_set[CAUSE_IBPERR] = ibw_valid && ibw_perr;
      cause_set[CAUSE_IBREXC] = sysr_valid && sysr_excep;
      // Posted inbound writes cannot report back: the flag is dropped.
      posted_excep_unused = sysw_excep;
   end

   ob_wr_buffer #(.DW(DW), .DEPTH(DEPTH)) u_obw (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (obw_push),
      .din   (obw_data),
      .pop   (obw_pop),
      .flush (wr_abort),
      .dout  (obw_rdata),
      .avail (obw_avail),
      .full  (obw_full)
   );

   ob_rd_tracker #(.DW(DW), .LW(LW)) u_obr (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (obr_start),
      .len       (obr_len),
      .pci_valid (obr_pci_valid),
      .pci_data  (obr_pci_data),
      .abort     (rd_abort),
      .busy      (obr_busy),
      .rsp_valid (rsp_valid),
      .rsp_data  (rsp_data),
      .rsp_err   (rsp_err),
      .rsp_last  (rsp_last)
   );

   ib_pass_stage #(.DW(DW)) u_ibw (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (ibw_valid),
      .in_data   (ibw_data),
      .out_valid (sysw_valid),
      .out_data  (sysw_data)
   );

   ib_pass_stage #(.DW(DW)) u_ibr (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (sysr_valid),
      .in_data   (sysr_data),
      .out_valid (pcir_valid),
      .out_data  (pcir_data)
   );

   err_csr #(.NC(NUM_CAUSES)) u_csr (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_vec (cause_set),
      .we      (csr_we),
      .wdata   (csr_wdata),
      .rdata   (csr_rdata),
      .irq     (smi_irq)
   );

   // R8: a posted-write exception alone never raises a status bit
   a_r8_posted_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (sysw_excep && cause_set == '0 && csr_rdata[7:4] == 4'h0) |=> (csr_rdata[7:4] == 4'h0));

   // R2: a write abort empties the buffer
   a_r2_abort_flush: assert property (@(posedge clk) disable iff (!rst_n)
      wr_abort |=> !obw_avail);
endmodule

// File: tb/pci_bridge_err_handler_test.sv
`timescale 1ns/1ps
module pci_bridge_err_handler_test;
   localparam int DW = 32;
   localparam int DEPTH = 4;
   localparam int LW = 4;

   logic clk = 1'b0;
   logic rst_n;
   logic obw_push, obw_pop, obw_mabort, obw_tabort, obw_full, obw_avail;
   logic [DW-1:0] obw_data, obw_rdata;
   logic obr_start, obr_busy, obr_pci_valid, obr_mabort, obr_tabort;
   logic [LW-1:0] obr_len;
   logic [DW-1:0] obr_pci_data, rsp_data;
   logic rsp_valid, rsp_err, rsp_last;
   logic ibw_valid, ibw_perr, sysw_valid, sysw_excep;
   logic [DW-1:0] ibw_data, sysw_data, sysr_data, pcir_data;
   logic sysr_valid, sysr_excep, pcir_valid;
   logic csr_we, smi_irq;
   logic [7:0] csr_wdata, csr_rdata;

   int tests = 0;
   int fails = 0;

   always #2.5 clk = ~clk;

   pci_bridge_err_handler #(.DW(DW), .DEPTH(DEPTH), .LW(LW)) uut (
      .clk(clk), .rst_n(rst_n),
      .obw_push(obw_push), .obw_data(obw_data), .obw_full(obw_full),
      .obw_pop(obw_pop), .obw_avail(obw_avail), .obw_rdata(obw_rdata),
      .obw_mabort(obw_mabort), .obw_tabort(obw_tabort),
      .obr_start(obr_start), .obr_len(obr_len), .obr_busy(obr_busy),
      .obr_pci_valid(obr_pci_valid), .obr_pci_data(obr_pci_data),
      .obr_mabort(obr_mabort), .obr_tabort(obr_tabort),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err), .rsp_last(rsp_last),
      .ibw_valid(ibw_valid), .ibw_data(ibw_data), .ibw_perr(ibw_perr),
      .sysw_valid(sysw_valid), .sysw_data(sysw_data), .sysw_excep(sysw_excep),
      .sysr_valid(sysr_valid), .sysr_data(sysr_data), .sysr_excep(sysr_excep),
      .pcir_valid(pcir_valid), .pcir_data(pcir_data),
      .csr_we(csr_we), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .smi_irq(smi_irq)
   );

   task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
      end
   endtask

   task automatic quiet();
      obw_push = 0; obw_data = '0; obw_pop = 0; obw_mabort = 0; obw_tabort = 0;
      obr_start = 0; obr_len = '0; obr_pci_valid = 0; obr_pci_data = '0;
      obr_mabort = 0; obr_tabort = 0;
      ibw_valid = 0; ibw_data = '0; ibw_perr = 0; sysw_excep = 0;
      sysr_valid = 0; sysr_data = '0; sysr_excep = 0;
      csr_we = 0; csr_wdata = '0;
   endtask

   // one clock: inputs already driven, advance to the next falling edge
   task automatic tick();
      @(posedge clk);
      @(negedge clk);
      quiet();
   endtask

   task automatic csr_write(input logic [7:0] v);
      csr_we = 1; csr_wdata = v;
      tick();
   endtask

   task automatic t_reset();
      quiet();
      rst_n = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk("R5 reset csr", csr_rdata, 8'h00);
      chk("R6 reset irq", smi_irq, 0);
      chk("R1 reset avail", obw_avail, 0);
      chk("R3 reset rsp/busy", {rsp_valid, obr_busy}, 2'b00);
   endtask

   task automatic t_write_order();
      for (int i = 0; i < DEPTH; i++) begin
         obw_push = 1; obw_data = 32'hA000_0000 + i;
         tick();
      end
      chk("R1 full at depth", obw_full, 1);
      obw_push = 1; obw_data = 32'hDEAD_BEEF;
      tick();
      for (int i = 0; i < DEPTH; i++) begin
         chk("R1 order", {obw_avail, obw_rdata}, {1'b1, 32'hA000_0000 + i});
         obw_pop = 1;
         tick();
      end
      chk("R1 dropped push absent", obw_avail, 0);
   endtask

   task automatic t_write_abort();
      for (int i = 0; i < 3; i++) begin
         obw_push = 1; obw_data = 32'hB000_0000 + i;
         tick();
      end
      obw_mabort = 1; obw_push = 1; obw_data = 32'h1234_5678;
      tick();
      chk("R2 flushed", {obw_avail, obw_full}, 2'b00);
      chk("R5 master abort bit", csr_rdata, 8'h10);
      chk("R6 irq masked", smi_irq, 0);
      repeat (2) tick();
      chk("R10 no reissue of write", obw_avail, 0);
      csr_write(8'h10);
      chk("R5 cleared", csr_rdata, 8'h00);
   endtask

   task automatic t_irq();
      csr_write(8'h0F);
      chk("R6 enables", csr_rdata, 8'h0F);
      obw_push = 1; obw_data = 32'h5;
      tick();
      obw_tabort = 1;
      tick();
      chk("R5 target abort bit", csr_rdata, 8'h2F);
      chk("R6 irq up", smi_irq, 1);
      chk("R2 flushed on target abort", obw_avail, 0);
      obw_tabort = 1; csr_we = 1; csr_wdata = 8'h2F;
      tick();
      chk("R5 set beats clear", csr_rdata, 8'h2F);
      csr_write(8'h2F);
      chk("R6 irq falls after clear", {smi_irq, csr_rdata}, {1'b0, 8'h0F});
   endtask

   task automatic t_read_normal();
      obr_start = 1; obr_len = 4'd3;
      tick();
      chk("R3 busy", obr_busy, 1);
      for (int i = 0; i < 3; i++) begin
         obr_pci_valid = 1; obr_pci_data = 32'hC000_0000 + i;
         tick();
         chk("R3 word", {rsp_valid, rsp_err, rsp_last, rsp_data},
             {1'b1, 1'b0, (i == 2), 32'hC000_0000 + i});
      end
      chk("R3 closed", obr_busy, 0);
   endtask

   task automatic t_read_abort();
      obr_start = 1; obr_len = 4'd4;
      tick();
      obr_pci_valid = 1; obr_pci_data = 32'hD000_0001;
      tick();
      chk("R3 first word", {rsp_valid, rsp_err, rsp_data}, {2'b10, 32'hD000_0001});
      obr_mabort = 1; obr_pci_valid = 1; obr_pci_data = 32'hD000_0002;
      tick();
      chk("R4 abort word dropped", rsp_valid, 0);
      chk("R5 read master abort", csr_rdata, 8'h1F);
      chk("R6 irq on read abort", smi_irq, 1);
      for (int i = 0; i < 3; i++) begin
         tick();
         chk("R4 filler", {rsp_valid, rsp_err, rsp_last, rsp_data},
             {1'b1, 1'b1, (i == 2), 32'hFFFF_FFFF});
      end
      for (int i = 0; i < 3; i++) begin
         obr_pci_valid = 1; obr_pci_data = 32'h77;
         tick();
         chk("R10 no response after abort", {rsp_valid, obr_busy}, 2'b00);
      end
      csr_write(8'h1F);
   endtask

   task automatic t_inbound_write();
      ibw_valid = 1; ibw_data = 32'hE0E0_1111; ibw_perr = 0;
      tick();
      chk("R7 clean forward", {sysw_valid, sysw_data}, {1'b1, 32'hE0E0_1111});
      chk("R7 no status clean", csr_rdata, 8'h0F);
      ibw_valid = 1; ibw_data = 32'hBAD0_2222; ibw_perr = 1;
      tick();
      chk("R7 corrupt forwarded", {sysw_valid, sysw_data}, {1'b1, 32'hBAD0_2222});
      chk("R7 parity bit", csr_rdata, 8'h4F);
      chk("R6 irq parity", smi_irq, 1);
      csr_write(8'h4F);
      chk("R5 parity cleared", csr_rdata, 8'h0F);
   endtask

   task automatic t_posted_excep();
      sysw_excep = 1;
      tick();
      sysw_excep = 1;
      tick();
      chk("R8 no status", csr_rdata, 8'h0F);
      chk("R8 no irq", smi_irq, 0);
   endtask

   task automatic t_inbound_read();
      sysr_valid = 1; sysr_data = 32'h0F0F_0001;
      tick();
      chk("R9 pass clean", {pcir_valid, pcir_data}, {1'b1, 32'h0F0F_0001});
      chk("R9 no status clean", csr_rdata, 8'h0F);
      sysr_valid = 1; sysr_data = 32'h0F0F_0002; sysr_excep = 1;
      tick();
      chk("R9 pass flagged", {pcir_valid, pcir_data}, {1'b1, 32'h0F0F_0002});
      chk("R9 exception bit", csr_rdata, 8'h8F);
      chk("R6 irq exception", smi_irq, 1);
   endtask

   initial begin
      #1000000;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      @(negedge clk);
      t_reset();
      t_write_order();
      t_write_abort();
      t_irq();
      t_read_normal();
      t_read_abort();
      t_inbound_write();
      t_posted_excep();
      t_inbound_read();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule